// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block is the interlock for a five-stage in-order pipeline. It looks for one situation only: a load sits in the execute slot, and the instruction behind it in decode reads the register that the load is about to fill. A forwarding network cannot bridge that gap, because the loaded value is not available until the memory stage. In that case the unit freezes the program counter and the fetch/decode register for one cycle. It also sends an empty slot down the pipe by writing all-zero control into the decode/execute register.

The block carries a minimal pipeline skeleton around the interlock, so that its effect can be seen at the ports. The skeleton is a program counter, a fetch/decode register that holds three register fields and a control bundle, and a decode/execute register that holds the same fields. The instruction fields and their control bundle come in through a fetch port. The caller drives that port from the current program counter. Forwarding, arithmetic, memories and branches are outside this block.

Top module: `ld_use_pipe`

## Requirements
- R1: A stall is raised in a cycle when the decode/execute control has its memory-read bit set (bit 5 of the control bundle), its destination field `idex_rt` is nonzero, and that field equals the `rs` or the `rt` field held in fetch/decode.
- R2: No stall is raised when the instruction in decode/execute is not a load, even if its `rt` field equals a source field in fetch/decode.
- R3: A load whose destination is register 0 never causes a stall, whatever the fields in fetch/decode are.
- R4: While stalled, `pc_we` and `ifid_we` are low and `bubble_sel` is high. At the next edge the program counter and the fetch/decode fields keep their values.
- R5: The edge that ends a stall cycle writes an all-zero control bundle into decode/execute. The register fields of the held instruction are still copied into it.
- R6: A single load followed by a dependent instruction costs exactly one stall cycle. The cycle after a stall never stalls, and the held instruction enters decode/execute one cycle later.
- R7: An active-high synchronous reset clears the program counter, fetch/decode and decode/execute to zero. No stall is raised while reset is high.
- R8: Without a stall, each edge adds 4 to the program counter, loads the fetch port into fetch/decode, and moves the fetch/decode fields and control bundle into decode/execute unchanged. Control bundle layout: bit 7 register write, bit 6 memory-to-register, bit 5 memory read, bit 4 memory write, bits 3:2 ALU op, bit 1 ALU source, bit 0 destination select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| fetch_rs | input | REG_W | First source field of the fetched instruction |
| fetch_rt | input | REG_W | Second source / load destination field of the fetched instruction |
| fetch_rd | input | REG_W | Result destination field of the fetched instruction |
| fetch_ctrl | input | CTRL_W | Control bundle of the fetched instruction |
| pc_q | output | PC_W | Program counter |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | Zero the control written into decode/execute |
| ifid_rs | output | REG_W | `rs` field held in fetch/decode |
| ifid_rt | output | REG_W | `rt` field held in fetch/decode |
| idex_ctrl | output | CTRL_W | Control bundle held in decode/execute |
| idex_rs | output | REG_W | `rs` field held in decode/execute |
| idex_rt | output | REG_W | `rt` field held in decode/execute |
| idex_rd | output | REG_W | `rd` field held in decode/execute |

## Verification
The bench runs a short program with a load followed by a dependent ALU op, a match only in the `rt` field, and a matching non-load. It also has a load into register 0, a store that depends on a load, and two dependent loads back to back. A design that ignores the load bit stalls behind the ALU op. One that does not exclude register 0 inserts a stray bubble. One that re-stalls on the held instruction loses a cycle on every load.

Per-cycle checks of the program counter and the decode/execute contents catch a bubble that leaves control bits set, and a stall that lets the program counter or fetch/decode move. A reset asserted in the middle of a stall must drop the stall at once and clear the pipe.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef struct packed {
    logic       reg_write;
    logic       mem_to_reg;
    logic       mem_read;
    logic       mem_write;
    logic [1:0] alu_op;
    logic       alu_src;
    logic       reg_dst;
  } lu_ctrl_t;

  localparam int CTRL_W = $bits(lu_ctrl_t);

  // Squash a control bundle into a no-op slot when kill is set.
  function automatic lu_ctrl_t lu_squash(lu_ctrl_t c, logic kill);
    return kill ? lu_ctrl_t'('0) : c;
  endfunction

endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int REG_W = 5
) (
  input  logic             rst,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  output logic             load_use_hit,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             bubble_sel
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  function automatic logic dep_on_load(logic is_load, logic [REG_W-1:0] dst,
                                       logic [REG_W-1:0] a, logic [REG_W-1:0] b);
    return is_load && (dst != ZERO_REG) && ((dst == a) || (dst == b));
  endfunction

  assign load_use_hit = !rst && dep_on_load(ex_is_load, ex_dst, dec_rs, dec_rt);
  assign pc_we        = !load_use_hit;
  assign ifid_we      = !load_use_hit;
  assign bubble_sel   = load_use_hit;

endmodule

// File: rtl/lu_ifid_stage.sv
module lu_ifid_stage #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] in_rs,
  input  logic [REG_W-1:0] in_rt,
  input  logic [REG_W-1:0] in_rd,
  input  lu_pkg::lu_ctrl_t in_ctrl,
  output logic [REG_W-1:0] q_rs,
  output logic [REG_W-1:0] q_rt,
  output logic [REG_W-1:0] q_rd,
  output lu_pkg::lu_ctrl_t q_ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_rs   <= '0;
      q_rt   <= '0;
      q_rd   <= '0;
      q_ctrl <= '0;
    end else if (we) begin
      q_rs   <= in_rs;
      q_rt   <= in_rt;
      q_rd   <= in_rd;
      q_ctrl <= in_ctrl;
    end
  end

endmodule

// File: rtl/lu_idex_stage.sv
module lu_idex_stage #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bubble,
  input  logic [REG_W-1:0] in_rs,
  input  logic [REG_W-1:0] in_rt,
  input  logic [REG_W-1:0] in_rd,
  input  lu_pkg::lu_ctrl_t in_ctrl,
  output logic [REG_W-1:0] q_rs,
  output logic [REG_W-1:0] q_rt,
  output logic [REG_W-1:0] q_rd,
  output lu_pkg::lu_ctrl_t q_ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_rs   <= '0;
      q_rt   <= '0;
      q_rd   <= '0;
      q_ctrl <= '0;
    end else begin
      q_rs   <= in_rs;
      q_rt   <= in_rt;
      q_rd   <= in_rd;
      q_ctrl <= lu_pkg::lu_squash(in_ctrl, bubble);
    end
  end

endmodule

// File: rtl/ld_use_pipe.sv
module ld_use_pipe #(
  parameter int REG_W       = 5,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [REG_W-1:0]          fetch_rs,
  input  logic [REG_W-1:0]          fetch_rt,
  input  logic [REG_W-1:0]          fetch_rd,
  input  logic [lu_pkg::CTRL_W-1:0] fetch_ctrl,
  output logic [PC_W-1:0]           pc_q,
  output logic                      pc_we,
  output logic                      ifid_we,
  output logic                      bubble_sel,
  output logic [REG_W-1:0]          ifid_rs,
  output logic [REG_W-1:0]          ifid_rt,
  output logic [lu_pkg::CTRL_W-1:0] idex_ctrl,
  output logic [REG_W-1:0]          idex_rs,
  output logic [REG_W-1:0]          idex_rt,
  output logic [REG_W-1:0]          idex_rd
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_BYTES);

  lu_pkg::lu_ctrl_t fetch_ctrl_s;
  lu_pkg::lu_ctrl_t ifid_ctrl_s;
  lu_pkg::lu_ctrl_t idex_ctrl_s;
  logic [REG_W-1:0] ifid_rd;
  logic             load_use_hit;

  assign fetch_ctrl_s = fetch_ctrl;
  assign idex_ctrl    = idex_ctrl_s;

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (pc_we) pc_q <= pc_q + PC_STEP;
  end

  lu_ifid_stage #(.REG_W(REG_W)) u_ifid (
    .clk     (clk),
    .rst     (rst),
    .we      (ifid_we),
    .in_rs   (fetch_rs),
    .in_rt   (fetch_rt),
    .in_rd   (fetch_rd),
    .in_ctrl (fetch_ctrl_s),
    .q_rs    (ifid_rs),
    .q_rt    (ifid_rt),
    .q_rd    (ifid_rd),
    .q_ctrl  (ifid_ctrl_s)
  );

  lu_hazard_detect #(.REG_W(REG_W)) u_hazard (
    .rst          (rst),
    .ex_is_load   (idex_ctrl_s.mem_read),
    .ex_dst       (idex_rt),
    .dec_rs       (ifid_rs),
    .dec_rt       (ifid_rt),
    .load_use_hit (load_use_hit),
    .pc_we        (pc_we),
    .ifid_we      (ifid_we),
    .bubble_sel   (bubble_sel)
  );

  lu_idex_stage #(.REG_W(REG_W)) u_idex (
    .clk     (clk),
    .rst     (rst),
    .bubble  (bubble_sel),
    .in_rs   (ifid_rs),
    .in_rt   (ifid_rt),
    .in_rd   (ifid_rd),
    .in_ctrl (ifid_ctrl_s),
    .q_rs    (idex_rs),
    .q_rt    (idex_rt),
    .q_rd    (idex_rd),
    .q_ctrl  (idex_ctrl_s)
  );

endmodule

// File: rtl/lu_stall_checker.sv
module lu_stall_checker #(
  parameter int REG_W = 5,
  parameter int PC_W  = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      load_use_hit,
  input logic                      pc_we,
  input logic                      ifid_we,
  input logic                      bubble_sel,
  input logic [PC_W-1:0]           pc_q,
  input logic [REG_W-1:0]          ifid_rs,
  input logic [REG_W-1:0]          ifid_rt,
  input logic [lu_pkg::CTRL_W-1:0] idex_ctrl,
  input logic [REG_W-1:0]          idex_rt
);

  localparam int MEM_RD_BIT = 5;

  assert_stall_needs_load_R1: assert property (@(posedge clk) disable iff (rst)
    load_use_hit |-> idex_ctrl[MEM_RD_BIT]);

  assert_stall_needs_match_R1: assert property (@(posedge clk) disable iff (rst)
    load_use_hit |-> (idex_rt == ifid_rs || idex_rt == ifid_rt));

  assert_no_zero_reg_stall_R3: assert property (@(posedge clk) disable iff (rst)
    load_use_hit |-> idex_rt != '0);

  assert_enables_R4: assert property (@(posedge clk) disable iff (rst)
    bubble_sel |-> (!pc_we && !ifid_we));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    load_use_hit |=> (pc_q == $past(pc_q) && ifid_rs == $past(ifid_rs)
                      && ifid_rt == $past(ifid_rt)));

  assert_bubble_zero_R5: assert property (@(posedge clk) disable iff (rst)
    bubble_sel |=> idex_ctrl == '0);

  assert_single_stall_R6: assert property (@(posedge clk) disable iff (rst)
    load_use_hit |=> !load_use_hit);

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && idex_ctrl == '0));

  always_comb begin
    if (rst) assert_no_stall_in_reset_R7: assert (!load_use_hit);
  end

  assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> pc_q == $past(pc_q) + PC_W'(4));

endmodule

bind ld_use_pipe lu_stall_checker #(.REG_W(REG_W), .PC_W(PC_W)) u_stall_chk (
  .clk          (clk),
  .rst          (rst),
  .load_use_hit (load_use_hit),
  .pc_we        (pc_we),
  .ifid_we      (ifid_we),
  .bubble_sel   (bubble_sel),
  .pc_q         (pc_q),
  .ifid_rs      (ifid_rs),
  .ifid_rt      (ifid_rt),
  .idex_ctrl    (idex_ctrl),
  .idex_rt      (idex_rt)
);

// File: tb/tb_ld_use_pipe.sv
module tb_ld_use_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;
  localparam int PC_W  = 32;
  localparam int CW    = 8;
  localparam int ROWS  = 22;

  // Control encodings (bit7 wr, bit6 m2r, bit5 mrd, bit4 mwr, 3:2 op, 1 src, 0 dst)
  localparam logic [7:0] C_LD  = 8'hE2;
  localparam logic [7:0] C_ALU = 8'h89;
  localparam logic [7:0] C_ST  = 8'h12;

  // Expected per cycle after reset release: {pc[7:0], stall, idex_ctrl, idex_rt}
  localparam logic [21:0] EXP [ROWS] = '{
    {8'd0,  1'b0, 8'h00, 5'd0},
    {8'd4,  1'b0, 8'h00, 5'd0},
    {8'd8,  1'b1, 8'hE2, 5'd2},
    {8'd8,  1'b0, 8'h00, 5'd3},
    {8'd12, 1'b0, 8'h89, 5'd3},
    {8'd16, 1'b1, 8'hE2, 5'd5},
    {8'd16, 1'b0, 8'h00, 5'd5},
    {8'd20, 1'b0, 8'h89, 5'd5},
    {8'd24, 1'b0, 8'h89, 5'd6},
    {8'd28, 1'b0, 8'hE2, 5'd0},
    {8'd32, 1'b0, 8'h89, 5'd0},
    {8'd36, 1'b0, 8'hE2, 5'd10},
    {8'd40, 1'b0, 8'h89, 5'd12},
    {8'd44, 1'b0, 8'h12, 5'd10},
    {8'd48, 1'b1, 8'hE2, 5'd14},
    {8'd48, 1'b0, 8'h00, 5'd3},
    {8'd52, 1'b0, 8'h12, 5'd3},
    {8'd56, 1'b1, 8'hE2, 5'd15},
    {8'd56, 1'b0, 8'h00, 5'd16},
    {8'd60, 1'b1, 8'hE2, 5'd16},
    {8'd60, 1'b0, 8'h00, 5'd16},
    {8'd64, 1'b0, 8'h89, 5'd16}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] fetch_rs, fetch_rt, fetch_rd;
  logic [CW-1:0]    fetch_ctrl;
  logic [PC_W-1:0]  pc_q;
  logic             pc_we, ifid_we, bubble_sel;
  logic [REG_W-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd;
  logic [CW-1:0]    idex_ctrl;

  int n_tests = 0;
  int n_fail  = 0;
  int n_stall = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_use_pipe #(.REG_W(REG_W), .PC_W(PC_W)) dut (
    .clk(clk), .rst(rst),
    .fetch_rs(fetch_rs), .fetch_rt(fetch_rt), .fetch_rd(fetch_rd),
    .fetch_ctrl(fetch_ctrl),
    .pc_q(pc_q), .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble_sel),
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
    .idex_ctrl(idex_ctrl), .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd)
  );

  // Program memory: {rs, rt, rd, ctrl} indexed by pc/4
  function automatic logic [22:0] prog(logic [PC_W-1:0] pc);
    case (pc[PC_W-1:2])
      0:  return {5'd1,  5'd2,  5'd0,  C_LD};
      1:  return {5'd2,  5'd3,  5'd4,  C_ALU};
      2:  return {5'd1,  5'd5,  5'd0,  C_LD};
      3:  return {5'd6,  5'd5,  5'd7,  C_ALU};
      4:  return {5'd5,  5'd6,  5'd8,  C_ALU};
      5:  return {5'd1,  5'd0,  5'd0,  C_LD};
      6:  return {5'd0,  5'd0,  5'd9,  C_ALU};
      7:  return {5'd1,  5'd10, 5'd0,  C_LD};
      8:  return {5'd11, 5'd12, 5'd13, C_ALU};
      9:  return {5'd10, 5'd10, 5'd0,  C_ST};
      10: return {5'd1,  5'd14, 5'd0,  C_LD};
      11: return {5'd14, 5'd3,  5'd0,  C_ST};
      12: return {5'd1,  5'd15, 5'd0,  C_LD};
      13: return {5'd15, 5'd16, 5'd0,  C_LD};
      14: return {5'd16, 5'd16, 5'd17, C_ALU};
      default: return '0;
    endcase
  endfunction

  always_comb {fetch_rs, fetch_rt, fetch_rd, fetch_ctrl} = prog(pc_q);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [REG_W-1:0] prev_rs;
    logic [REG_W-1:0] prev_rt;
    logic             prev_stall;
    prev_rs = '0; prev_rt = '0; prev_stall = 1'b0;

    // R7: reset state, no stall during reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7", "pc in reset", pc_q, 0);
    check("R7", "idex_ctrl in reset", 32'(idex_ctrl), 0);
    check("R7", "stall in reset", 32'(bubble_sel), 0);
    check("R7", "ifid_rs in reset", 32'(ifid_rs), 0);
    rst = 1'b0;

    // Program walk: R1 R2 R3 R5 R6 R8 per row
    for (int i = 0; i < ROWS; i++) begin
      logic [7:0] e_pc;
      logic       e_st;
      logic [7:0] e_ct;
      logic [4:0] e_rt;
      {e_pc, e_st, e_ct, e_rt} = EXP[i];
      check("R8", $sformatf("pc row %0d", i), pc_q, 32'(e_pc));
      check("R1", $sformatf("stall row %0d (R2 R3 R6)", i), 32'(bubble_sel), 32'(e_st));
      check("R5", $sformatf("idex_ctrl row %0d", i), 32'(idex_ctrl), 32'(e_ct));
      check("R8", $sformatf("idex_rt row %0d", i), 32'(idex_rt), 32'(e_rt));
      check("R4", $sformatf("pc_we row %0d", i), 32'(pc_we), 32'(!e_st));
      check("R4", $sformatf("ifid_we row %0d", i), 32'(ifid_we), 32'(!e_st));
      if (prev_stall) begin
        check("R4", $sformatf("ifid_rs held row %0d", i), 32'(ifid_rs), 32'(prev_rs));
        check("R4", $sformatf("ifid_rt held row %0d", i), 32'(ifid_rt), 32'(prev_rt));
      end
      if (bubble_sel) n_stall++;
      prev_rs = ifid_rs; prev_rt = ifid_rt; prev_stall = bubble_sel;
      @(posedge clk);
      @(negedge clk);
    end
    check("R6", "total stall cycles", 32'(n_stall), 5);

    // R7: reset asserted while a stall is active
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1", "stall re-run after reset", 32'(bubble_sel), 1);
    rst = 1'b1;
    #1;
    check("R7", "stall dropped by reset", 32'(bubble_sel), 0);
    @(posedge clk); @(negedge clk);
    check("R7", "pc cleared", pc_q, 0);
    check("R7", "idex_ctrl cleared", 32'(idex_ctrl), 0);
    check("R7", "idex_rt cleared", 32'(idex_rt), 0);
    check("R7", "ifid_rt cleared", 32'(ifid_rt), 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8", "pc advances after reset", pc_q, 4);

    done = 1'b1;
    summary();
  end

endmodule